// File: doc/BRIEF.md
# Serialized Interrupt Line Agent

This block is the peripheral end of a shared, open-drain serial interrupt wire that runs on the bus clock. The line idles high through a pull-up. A host opens each interrupt cycle by holding the line low for several clocks. The agent detects that opening pulse and stores its pending interrupt vector at that moment. It then counts clocks through a fixed train of time slots. Every slot is three clocks long: a sample clock, a recover clock and a turnaround clock.

The vector has sixteen interrupt slots and one channel-check slot. In the sample clock of a slot whose request is pending, the agent pulls the line low. In the recover clock that follows, it drives the line high for one clock. In the turnaround clock, it lets go of the line so that the next driver can take it. Slots that are not pending are never driven. After the last slot the agent waits for the host's closing pulse and then returns to idle. The block only gives enables to an external buffer. It also gives back a registered copy of the line.

Top module: `sirq_agent`

## Requirements
- R1: `line_q` equals the value of `sirq_in` one clock earlier. Reset sets it to 1.
- R2: In idle, a cycle opens only when the line goes high after at least START_MIN (4) consecutive low clocks. A shorter low pulse causes no drive at all.
- R3: If the line first returns high in clock X, the sample clock of slot k is clock X+2+3k. `drv_low` is 1 in that clock when bit k of the stored vector is 1.
- R4: `drv_high` is 1 in exactly the clock that follows each clock in which `drv_low` was 1, and in no other clock.
- R5: In the turnaround clock of every slot, both `drv_low` and `drv_high` are 0.
- R6: A slot whose stored bit is 0 gets no drive in any of its three clocks.
- R7: Slot 16, right after interrupt 15, carries `iochk_pending`. It is bit 16 of the stored vector {iochk_pending, irq_pending}, and bit k below 16 is irq_pending[k].
- R8: The vector is stored in the clock in which the opening pulse is detected. Input changes after that have no effect until the next cycle.
- R9: After the last slot, a low pulse of at least STOP_MIN (2) clocks followed by a high clock closes the cycle. The agent then returns to idle, and the very next low pulse can open a new cycle.
- R10: Outside the slot train (idle, the opening pulse, the closing pulse), both enables are 0.
- R11: `drv_low` and `drv_high` are never 1 in the same clock.
- R12: Reset clears the stored vector and both enables, and puts the agent in idle. This applies even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sirq_in | input | 1 | Level currently seen on the shared line |
| irq_pending | input | NUM_IRQ (16) | Pending interrupt requests; bit k is slot k |
| iochk_pending | input | 1 | Pending channel-check request (last slot) |
| drv_low | output | 1 | Enable to pull the line low |
| drv_high | output | 1 | Enable to drive the line high |
| line_q | output | 1 | Line level registered one clock |

## Verification
The bench replays host-driven cycles and predicts the enable levels for every clock from the stored vector. The stimulus includes an all-pending vector, an empty vector, a vector with only the channel-check bit set, a vector with only the edge slots set, and random vectors. These separate slot-position faults (off-by-one slot or phase) from polarity faults and from a missing last slot. Opening pulses of random length and closing pulses of 2 or 3 clocks check that detection depends on the pulse length and not on its exact value. A vector that flips right after it is stored shows whether the block samples its inputs late. A 3-clock low pulse, a reset in the middle of a cycle, and a cycle that opens right after a close test the idle and restart paths.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_RECOV  = 2'd1,
    PH_TURN   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FRAMES    = 2'd1,
    ST_WAIT_STOP = 2'd2
  } seq_state_t;

endpackage

// File: rtl/sirq_line_mon.sv
module sirq_line_mon #(
  parameter int START_MIN = 4,
  parameter int STOP_MIN  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_q,
  output logic start_det,
  output logic stop_det
);
  localparam int RUN_MAX = (START_MIN > STOP_MIN) ? START_MIN : STOP_MIN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [RUN_W-1:0] low_run;
  logic             seen_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= 1'b1;
      low_run  <= '0;
      seen_run <= 1'b0;
    end else begin
      line_q   <= line_in;
      seen_run <= 1'b1;
      if (!line_q) begin
        if (low_run != RUN_W'(RUN_MAX)) low_run <= low_run + 1'b1;
      end else begin
        low_run <= '0;
      end
    end
  end

  // a finished low pulse is recognised on the first high sample after it
  assign start_det = line_q && (low_run >= RUN_W'(START_MIN));
  assign stop_det  = line_q && (low_run >= RUN_W'(STOP_MIN));

  p_line_follow_r1: assert property (@(posedge clk) disable iff (rst)
    seen_run |-> (line_q == $past(line_in)));

  p_detect_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (seen_run && start_det) |-> !$past(line_q));

endmodule

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start_det,
  input  logic                             stop_det,
  output logic                             load,
  output logic                             nxt_active,
  output logic [$clog2(NUM_IRQ+1)-1:0]     nxt_slot,
  output phase_t                           nxt_phase
);
  localparam int NUM_SLOTS = NUM_IRQ + 1;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int LAST_SLOT = NUM_SLOTS - 1;

  seq_state_t        state, nxt_state;
  logic [SLOT_W-1:0] slot;
  phase_t            phase;

  always_comb begin
    nxt_state = state;
    nxt_slot  = slot;
    nxt_phase = phase;
    load      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_det) begin
          nxt_state = ST_FRAMES;
          nxt_slot  = '0;
          nxt_phase = PH_SAMPLE;
          load      = 1'b1;
        end
      end
      ST_FRAMES: begin
        unique case (phase)
          PH_SAMPLE: nxt_phase = PH_RECOV;
          PH_RECOV:  nxt_phase = PH_TURN;
          default: begin
            nxt_phase = PH_SAMPLE;
            if (slot == SLOT_W'(LAST_SLOT)) begin
              nxt_state = ST_WAIT_STOP;
              nxt_slot  = '0;
            end else begin
              nxt_slot = slot + 1'b1;
            end
          end
        endcase
      end
      ST_WAIT_STOP: begin
        if (stop_det) nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  assign nxt_active = (nxt_state == ST_FRAMES);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      slot  <= '0;
      phase <= PH_SAMPLE;
    end else begin
      state <= nxt_state;
      slot  <= nxt_slot;
      phase <= nxt_phase;
    end
  end

  p_slot_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FRAMES) |-> (slot <= SLOT_W'(LAST_SLOT)));

  p_slot_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FRAMES && phase == PH_TURN && slot != SLOT_W'(LAST_SLOT))
    |=> (state == ST_FRAMES && phase == PH_SAMPLE && slot == $past(slot) + 1'b1));

  p_train_ends_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FRAMES && phase == PH_TURN && slot == SLOT_W'(LAST_SLOT))
    |=> (state == ST_WAIT_STOP));

endmodule

// File: rtl/sirq_drive.sv
module sirq_drive
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic                         nxt_active,
  input  logic [$clog2(NUM_IRQ+1)-1:0] nxt_slot,
  input  phase_t                       nxt_phase,
  input  logic [NUM_IRQ-1:0]           irq_pending,
  input  logic                         iochk_pending,
  output logic                         drv_low,
  output logic                         drv_high
);
  localparam int NUM_SLOTS = NUM_IRQ + 1;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0] vec_in, pend_lat, sel_vec;
  logic                 slot_bit;
  logic                 seen_run;

  assign vec_in  = {iochk_pending, irq_pending};
  // the first sample slot is decided in the same clock the vector is stored
  assign sel_vec = load ? vec_in : pend_lat;

  always_comb begin
    slot_bit = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (nxt_slot == SLOT_W'(i)) slot_bit = sel_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_lat <= '0;
      drv_low  <= 1'b0;
      drv_high <= 1'b0;
      seen_run <= 1'b0;
    end else begin
      seen_run <= 1'b1;
      if (load) pend_lat <= vec_in;
      drv_low  <= nxt_active && (nxt_phase == PH_SAMPLE) && slot_bit;
      drv_high <= nxt_active && (nxt_phase == PH_RECOV) && drv_low;
    end
  end

  p_enables_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(drv_low && drv_high));

  p_recover_follows_r4: assert property (@(posedge clk) disable iff (rst)
    drv_low |=> (drv_high && !drv_low));

  p_high_needs_low_r4: assert property (@(posedge clk) disable iff (rst)
    (seen_run && drv_high) |-> $past(drv_low));

  p_turn_released_r5: assert property (@(posedge clk) disable iff (rst)
    drv_high |=> (!drv_high && !drv_low));

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ   = 16,
  parameter int START_MIN = 4,
  parameter int STOP_MIN  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sirq_in,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic               iochk_pending,
  output logic               drv_low,
  output logic               drv_high,
  output logic               line_q
);
  localparam int SLOT_W = $clog2(NUM_IRQ + 1);

  logic              start_det, stop_det;
  logic              load, nxt_active;
  logic [SLOT_W-1:0] nxt_slot;
  phase_t            nxt_phase;

  sirq_line_mon #(
    .START_MIN (START_MIN),
    .STOP_MIN  (STOP_MIN)
  ) u_mon (
    .clk       (clk),
    .rst       (rst),
    .line_in   (sirq_in),
    .line_q    (line_q),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  sirq_frame_seq #(
    .NUM_IRQ (NUM_IRQ)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .load       (load),
    .nxt_active (nxt_active),
    .nxt_slot   (nxt_slot),
    .nxt_phase  (nxt_phase)
  );

  sirq_drive #(
    .NUM_IRQ (NUM_IRQ)
  ) u_drv (
    .clk           (clk),
    .rst           (rst),
    .load          (load),
    .nxt_active    (nxt_active),
    .nxt_slot      (nxt_slot),
    .nxt_phase     (nxt_phase),
    .irq_pending   (irq_pending),
    .iochk_pending (iochk_pending),
    .drv_low       (drv_low),
    .drv_high      (drv_high)
  );

  p_no_drive_in_reset_r12: assert property (@(posedge clk)
    $past(rst) |-> (!drv_low && !drv_high));

endmodule

// File: tb/sirq_agent_test.sv
module sirq_agent_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sirq_in = 1'b1;
  logic [15:0] irq_pending = '0;
  logic        iochk_pending = 1'b0;
  logic        drv_low, drv_high, line_q;

  int checks = 0;
  int failures = 0;
  logic prev_line = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sirq_agent uut (
    .clk           (clk),
    .rst           (rst),
    .sirq_in       (sirq_in),
    .irq_pending   (irq_pending),
    .iochk_pending (iochk_pending),
    .drv_low       (drv_low),
    .drv_high      (drv_high),
    .line_q        (line_q)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int enc(input logic lo, input logic hi);
    return {30'd0, hi, lo};
  endfunction

  // one bus clock: check the outputs for this clock, then put the line level on the wire
  task automatic step(input logic host_v, input logic exp_lo, input logic exp_hi, input string tag);
    logic line_now;
    @(negedge clk);
    check((drv_low === exp_lo) && (drv_high === exp_hi), tag,
          enc(drv_low, drv_high), enc(exp_lo, exp_hi));
    check(!(drv_low && drv_high), "R11", enc(drv_low, drv_high), 0);
    check(line_q === prev_line, "R1", int'(line_q), int'(prev_line));
    line_now  = host_v & ~drv_low;
    sirq_in   = line_now;
    prev_line = line_now;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sirq_in = 1'b1;
    prev_line = 1'b1;
    repeat (3) @(negedge clk);
    check(!drv_low && !drv_high, "R12", enc(drv_low, drv_high), 0);
    check(line_q === 1'b1, "R12", int'(line_q), 1);
    rst = 1'b0;
  endtask

  function automatic string sample_tag(input int k, input logic [16:0] pend, input logic [16:0] later);
    if (later != pend) return "R8";
    if (k == 16) return "R7";
    return pend[k] ? "R3" : "R6";
  endfunction

  task automatic run_cycle(input int low_len, input logic [16:0] pend, input logic [16:0] later,
                           input int stop_len, input int gap);
    {iochk_pending, irq_pending} = pend;
    for (int i = 0; i < low_len; i++) step(1'b0, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b0, 1'b0, "R2");    // opening pulse recover clock
    step(1'b1, 1'b0, 1'b0, "R2");    // opening pulse turnaround; vector stored at next edge
    for (int k = 0; k < NSLOT; k++) begin
      step(1'b1, pend[k], 1'b0, sample_tag(k, pend, later));
      if (k == 0) {iochk_pending, irq_pending} = later;
      step(1'b1, 1'b0, pend[k], pend[k] ? "R4" : "R6");
      step(1'b1, 1'b0, 1'b0, "R5");
    end
    for (int i = 0; i < stop_len; i++) step(1'b0, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b0, "R9");
    for (int i = 0; i < gap; i++) step(1'b1, 1'b0, 1'b0, "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [16:0] p, q;
    int          ll, sl, gp;
    void'($urandom(32'd20240611));
    do_reset();

    // directed vectors
    run_cycle(4, 17'h1FFFF, 17'h1FFFF, 2, 2);
    run_cycle(5, 17'h00000, 17'h00000, 3, 1);
    run_cycle(4, 17'h10000, 17'h10000, 2, 0);   // channel-check slot only (R7)
    run_cycle(6, 17'h08001, 17'h08001, 2, 0);   // edge slots, back to back (R9)
    run_cycle(4, 17'h0A5A5, 17'h15A5A, 2, 3);   // vector flips after storage (R8)

    // short low pulse must not open a cycle (R2)
    {iochk_pending, irq_pending} = 17'h1FFFF;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0, "R2");
    run_cycle(4, 17'h00F0F, 17'h00F0F, 3, 2);

    // reset in the middle of a cycle (R12)
    {iochk_pending, irq_pending} = 17'h1FFFF;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b1, 1'b0, "R3");
    do_reset();
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0, "R12");

    // random cycles
    for (int c = 0; c < 24; c++) begin
      p  = 17'($urandom());
      q  = (c % 3 == 0) ? 17'($urandom()) : p;
      ll = 4 + int'($urandom_range(0, 4));
      sl = 2 + int'($urandom_range(0, 1));
      gp = int'($urandom_range(0, 3));
      run_cycle(ll, p, q, sl, gp);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule